// File: doc/BRIEF.md
# Trimmed One-Second Prescaler

This block turns a stream of oscillator-rate enable pulses (nominally 32,768 per second) into a one-cycle seconds tick and a one-cycle minute strobe. It also trims the rate digitally. Trimming works over a repeating cycle of 2^CYC_W minutes, which is 64 by default. In each of the first 2×N minutes, the first second is made shorter or longer. N is a 5-bit magnitude and a sign input picks the direction.

The divider is built as two stages. A first stage counts 2^PRE_W enables (256 by default). A second stage counts SEC_DIV periods of the first stage (128 by default). Correction only changes the length of one first-stage period: the first period of the corrected second. With sign 0 that period lasts half the nominal length, so the second has 128 fewer enables. With sign 1 it lasts double the nominal length, so the second has 256 more enables. The magnitude and sign are taken at each minute boundary, and a stop input freezes the whole chain.

Top module: `cal_divider`

## Requirements
- R1: An uncorrected second spans exactly SEC_DIV × 2^PRE_W accepted enables (32,768 at default parameters). An accepted enable is a clock edge where osc_en_i is 1 and stop_i is 0.
- R2: min_tick_o pulses together with every SEC_PER_MIN-th sec_tick_o and never without it. Both are single-cycle pulses registered on the edge that accepts the last enable of the period.
- R3: With cal_pos_i = 0, a corrected second is shorter than nominal by half a first-stage period (128 enables at default).
- R4: With cal_pos_i = 1, a corrected second is longer than nominal by one full first-stage period (256 enables at default).
- R5: The corrected second is the first second of minute m, where m counts from 0 after reset, advances with each minute strobe, and wraps at 2^CYC_W. A minute is corrected when m < 2 × cal_mag_i.
- R6: The last two minutes of the cycle are never corrected, whatever the magnitude. A magnitude of 0 corrects no minute.
- R7: cal_mag_i and cal_pos_i are sampled on the first clock after reset and on each minute strobe edge. Changes between those points have no effect on the minute in progress.
- R8: While stop_i is 1, no tick is produced and both dividers and the minute index hold their values. Counting resumes from the held state.
- R9: Edges with osc_en_i = 0 do not advance the divider.
- R10: During reset and directly after it, both outputs are 0. The chain starts at the beginning of second 0 of minute 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| osc_en_i | input | 1 | Oscillator-rate count enable |
| stop_i | input | 1 | Freeze the divider chain |
| cal_mag_i | input | MAG_W | Correction magnitude N |
| cal_pos_i | input | 1 | Direction: 1 lengthens, 0 shortens |
| sec_tick_o | output | 1 | One-cycle pulse per second |
| min_tick_o | output | 1 | One-cycle pulse per minute |

## Verification
The minute strobe coincides with the last seconds tick of each minute, and the same edge samples the calibration inputs for the next minute. The bench changes the calibration twice in every minute: first to a decoy value after the first second, then to the intended value after the second second. It judges the result by the enable count of the first second of the following minute. In the same comparison it checks that the strobe arrives exactly with the fourth tick. A stop pulse and several enable duty patterns are applied while these boundaries pass, so the held state must carry across them.

// File: rtl/caldiv_pkg.sv
package caldiv_pkg;
  typedef enum logic [1:0] {
    CORR_NONE  = 2'd0,
    CORR_SHORT = 2'd1,
    CORR_LONG  = 2'd2
  } corr_e;
endpackage

// File: rtl/cal_window.sv
module cal_window
  import caldiv_pkg::*;
#(
  parameter int unsigned MAG_W = 5,
  parameter int unsigned CYC_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  input  logic [MAG_W-1:0] mag_i,
  input  logic             pos_i,
  output logic [CYC_W-1:0] min_idx_o,
  output corr_e            corr_o
);
  localparam int CYC_LEN = 1 << CYC_W;
  localparam int LAST_OK = CYC_LEN - 2;

  logic [CYC_W-1:0] idx_q, idx_d;
  logic             pend_q;
  corr_e            corr_q;
  logic [MAG_W:0]   win_len;
  logic             in_win;

  assign idx_d   = adv_i ? idx_q + 1'b1 : idx_q;
  assign win_len = {mag_i, 1'b0};
  // window is tested against the index of the minute about to start
  assign in_win  = (int'(idx_d) < int'(win_len)) && (int'(idx_d) < LAST_OK);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q  <= '0;
      pend_q <= 1'b1;
      corr_q <= CORR_NONE;
    end else begin
      idx_q <= idx_d;
      if (pend_q || adv_i) begin
        pend_q <= 1'b0;
        corr_q <= in_win ? (pos_i ? CORR_LONG : CORR_SHORT) : CORR_NONE;
      end
    end
  end

  assign min_idx_o = idx_q;
  assign corr_o    = corr_q;
endmodule

// File: rtl/pre_stage.sv
module pre_stage
  import caldiv_pkg::*;
#(
  parameter int unsigned PRE_W = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           step_i,
  input  corr_e          mode_i,
  output logic [PRE_W:0] cnt_o,
  output logic           tc_o
);
  localparam int unsigned NOM_LEN   = 1 << PRE_W;
  localparam int unsigned SHORT_LEN = NOM_LEN / 2;
  localparam int unsigned LONG_LEN  = 2 * NOM_LEN;

  logic [PRE_W:0] cnt_q, last;

  always_comb begin
    case (mode_i)
      CORR_SHORT: last = (PRE_W+1)'(SHORT_LEN - 1);
      CORR_LONG:  last = (PRE_W+1)'(LONG_LEN - 1);
      default:    last = (PRE_W+1)'(NOM_LEN - 1);
    endcase
  end

  assign tc_o = step_i && (cnt_q == last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (step_i) cnt_q <= tc_o ? '0 : cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/sec_stage.sv
module sec_stage #(
  parameter int unsigned SEC_DIV     = 128,
  parameter int unsigned SEC_PER_MIN = 60
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tc_i,
  output logic first_o,
  output logic sec_tc_o,
  output logic min_tc_o
);
  localparam int unsigned DIV_W = (SEC_DIV > 1) ? $clog2(SEC_DIV) : 1;
  localparam int unsigned SPM_W = (SEC_PER_MIN > 1) ? $clog2(SEC_PER_MIN) : 1;

  logic [DIV_W-1:0] div_q;
  logic [SPM_W-1:0] sec_q;

  assign sec_tc_o = tc_i && (div_q == DIV_W'(SEC_DIV - 1));
  assign min_tc_o = sec_tc_o && (sec_q == SPM_W'(SEC_PER_MIN - 1));
  assign first_o  = (div_q == '0) && (sec_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
      sec_q <= '0;
    end else if (tc_i) begin
      div_q <= sec_tc_o ? '0 : div_q + 1'b1;
      if (sec_tc_o) sec_q <= min_tc_o ? '0 : sec_q + 1'b1;
    end
  end
endmodule

// File: rtl/cal_divider.sv
module cal_divider
  import caldiv_pkg::*;
#(
  parameter int unsigned PRE_W       = 8,
  parameter int unsigned SEC_DIV     = 128,
  parameter int unsigned SEC_PER_MIN = 60,
  parameter int unsigned CYC_W       = 6,
  parameter int unsigned MAG_W       = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             osc_en_i,
  input  logic             stop_i,
  input  logic [MAG_W-1:0] cal_mag_i,
  input  logic             cal_pos_i,
  output logic             sec_tick_o,
  output logic             min_tick_o
);
  logic             step, pre_tc, first, sec_tc, min_tc;
  logic [PRE_W:0]   pre_cnt;
  logic [CYC_W-1:0] min_idx;
  corr_e            corr, mode_cur;
  logic             sec_q, min_q;

  assign step     = osc_en_i && !stop_i;
  assign mode_cur = first ? corr : CORR_NONE;

  pre_stage #(.PRE_W(PRE_W)) u_pre (
    .clk_i(clk_i), .rst_ni(rst_ni), .step_i(step), .mode_i(mode_cur),
    .cnt_o(pre_cnt), .tc_o(pre_tc)
  );

  sec_stage #(.SEC_DIV(SEC_DIV), .SEC_PER_MIN(SEC_PER_MIN)) u_sec (
    .clk_i(clk_i), .rst_ni(rst_ni), .tc_i(pre_tc),
    .first_o(first), .sec_tc_o(sec_tc), .min_tc_o(min_tc)
  );

  cal_window #(.MAG_W(MAG_W), .CYC_W(CYC_W)) u_win (
    .clk_i(clk_i), .rst_ni(rst_ni), .adv_i(min_tc),
    .mag_i(cal_mag_i), .pos_i(cal_pos_i),
    .min_idx_o(min_idx), .corr_o(corr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sec_q <= 1'b0;
      min_q <= 1'b0;
    end else begin
      sec_q <= sec_tc;
      min_q <= min_tc;
    end
  end

  assign sec_tick_o = sec_q;
  assign min_tick_o = min_q;
endmodule

// File: rtl/cal_divider_chk.sv
module cal_divider_chk
  import caldiv_pkg::*;
#(
  parameter int unsigned PRE_W = 8,
  parameter int unsigned CYC_W = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             osc_en_i,
  input logic             stop_i,
  input logic             sec_tick_o,
  input logic             min_tick_o,
  input logic [PRE_W:0]   pre_cnt,
  input logic [CYC_W-1:0] min_idx,
  input corr_e            corr
);
  localparam int LAST_OK = (1 << CYC_W) - 2;

  p_min_in_sec_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    min_tick_o |-> sec_tick_o);

  p_tick_needs_run_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_tick_o |-> $past(osc_en_i && !stop_i));

  p_stop_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> ($stable(pre_cnt) && $stable(min_idx)));

  p_idle_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !osc_en_i |=> $stable(pre_cnt));

  p_idx_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    min_tick_o |-> (min_idx == CYC_W'($past(min_idx) + 1'b1)));

  p_tail_clean_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (corr != CORR_NONE) |-> (int'(min_idx) < LAST_OK));
endmodule

bind cal_divider cal_divider_chk #(.PRE_W(PRE_W), .CYC_W(CYC_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .osc_en_i(osc_en_i), .stop_i(stop_i),
  .sec_tick_o(sec_tick_o), .min_tick_o(min_tick_o),
  .pre_cnt(pre_cnt), .min_idx(min_idx), .corr(corr)
);

// File: tb/sim_cal_divider.sv
module sim_cal_divider;
  localparam int CLK_PERIOD = 10;
  localparam int PRE_W  = 8;
  localparam int SEC_DIV = 4;
  localparam int SPM    = 4;
  localparam int CYC_W  = 3;
  localparam int CYC    = 1 << CYC_W;
  localparam int NOM    = SEC_DIV * (1 << PRE_W);
  localparam int N_MIN  = 10;

  typedef struct {
    int    len;
    bit    is_min;
    string tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       osc_en = 1'b0;
  logic       stop = 1'b0;
  logic [4:0] cal_mag = 5'd0;
  logic       cal_pos = 1'b0;
  logic       sec_tick, min_tick;

  exp_t q[$];
  int   consumed = 0, last_at = 0, sec_seen = 0, phase = 0;
  int   n_chk = 0, n_bad = 0, en_mode = 0;
  bit   stop_req = 0, prev_run = 0, prev_stop = 0;

  int mags[N_MIN] = '{1, 1, 2, 2, 3, 3, 31, 31, 0, 5};
  bit poss[N_MIN] = '{0, 0, 1, 1, 0, 0, 1, 1, 0, 1};
  int modes[N_MIN] = '{0, 0, 1, 1, 2, 2, 0, 0, 0, 1};

  always #(CLK_PERIOD/2) clk = ~clk;

  cal_divider #(.PRE_W(PRE_W), .SEC_DIV(SEC_DIV), .SEC_PER_MIN(SPM),
                .CYC_W(CYC_W), .MAG_W(5)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .osc_en_i(osc_en), .stop_i(stop),
    .cal_mag_i(cal_mag), .cal_pos_i(cal_pos),
    .sec_tick_o(sec_tick), .min_tick_o(min_tick)
  );

  task automatic push_minute(input int m, input int mag, input bit pos);
    for (int s = 0; s < SPM; s++) begin
      exp_t e;
      e.len = NOM;
      e.is_min = (s == SPM - 1);
      e.tag = "R1 R2";
      if (s == 0) begin
        if (m < 2 * mag && m < CYC - 2) begin
          e.len = pos ? NOM + 256 : NOM - 128;
          e.tag = pos ? "R4 R5 R7" : "R3 R5 R7";
        end else if (m >= CYC - 2 || mag == 0) begin
          e.tag = "R6 R7";
        end else begin
          e.tag = "R5 R7";
        end
      end
      q.push_back(e);
    end
  endtask

  // monitor then driver, both at the falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      consumed += int'(prev_run);
      if (prev_stop) begin
        n_chk++;
        if (sec_tick) begin
          n_bad++;
          $display("FAIL R8 tick while stopped: actual 1 expected 0");
        end
      end
      if (min_tick && !sec_tick) begin
        n_chk++; n_bad++;
        $display("FAIL R2 minute strobe alone: actual 1 expected 0");
      end
      if (sec_tick) begin
        if (q.size() == 0) begin
          n_chk++; n_bad++;
          $display("FAIL R1 unexpected tick: actual tick expected none");
        end else begin
          exp_t e;
          e = q.pop_front();
          n_chk++;
          if (consumed - last_at != e.len) begin
            n_bad++;
            $display("FAIL %s second %0d length: actual %0d expected %0d",
                     e.tag, sec_seen, consumed - last_at, e.len);
          end
          n_chk++;
          if (min_tick != e.is_min) begin
            n_bad++;
            $display("FAIL R2 minute strobe at second %0d: actual %0b expected %0b",
                     sec_seen, min_tick, e.is_min);
          end
        end
        last_at = consumed;
        sec_seen++;
      end
    end
    phase++;
    case (en_mode)
      1:       osc_en = rst_n && phase[0];
      2:       osc_en = rst_n && (phase % 3 != 0);
      default: osc_en = rst_n;
    endcase
    stop = stop_req;
    prev_run  = osc_en && !stop;
    prev_stop = stop;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual %0d seconds expected %0d", sec_seen, N_MIN * SPM);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    cal_mag = 5'(mags[0]);
    cal_pos = poss[0];
    en_mode = modes[0];
    push_minute(0, mags[0], poss[0]);
    repeat (4) @(negedge clk);
    n_chk++;
    if (sec_tick || min_tick) begin
      n_bad++;
      $display("FAIL R10 outputs in reset: actual %0b%0b expected 00", sec_tick, min_tick);
    end
    @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    #1;
    n_chk++;
    if (sec_tick || min_tick) begin
      n_bad++;
      $display("FAIL R10 outputs after reset: actual %0b%0b expected 00", sec_tick, min_tick);
    end
    for (int k = 0; k < N_MIN - 1; k++) begin
      wait (sec_seen == k * SPM + 1);
      // decoy mid-minute value; must not reach any minute (R7)
      cal_mag = 5'd31;
      cal_pos = ~poss[k + 1];
      wait (sec_seen == k * SPM + 2);
      cal_mag = 5'(mags[k + 1]);
      cal_pos = poss[k + 1];
      en_mode = modes[k + 1];
      push_minute((k + 1) % CYC, mags[k + 1], poss[k + 1]);
      if (k == 5) begin
        repeat (100) @(negedge clk);
        stop_req = 1'b1;
        repeat (300) @(negedge clk);
        stop_req = 1'b0;
      end
    end
    wait (sec_seen == N_MIN * SPM);
    repeat (5) @(negedge clk);
    n_chk++;
    if (q.size() != 0) begin
      n_bad++;
      $display("FAIL R1 pending seconds: actual %0d expected 0", q.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule